// File: doc/BRIEF.md
# Bus-Configured Triggered Logic Analyzer

This block is a small on-chip logic analyzer. It watches three single-bit probes and one 4-bit probe, and it is set up and read through a 16-bit memory-mapped request bus. The bus has an input port and an output port with the same fields, so several analyzer cores can be chained. Every request passes through the core with one cycle of delay. A request aimed at this core's own address window is acted on along the way: a write updates a register, and a read places the register value on the read-data field.

Software first writes a comparison operation and an argument for each probe, plus a signed trigger position. It then arms the core. While armed, the core records one probe sample on every clock edge into a circular sample memory. On each edge it also tests the enabled probe comparisons. When any of them matches, capture starts. Capture goes on until the memory holds exactly `SAMPLE_DEPTH` samples around the trigger point. The core then reports "done" and freezes. Software reads the samples back, oldest first, from the addresses that follow the configuration registers.

Top module: `bus_logic_analyzer`

## Requirements
- R1: A request whose address lies outside `[BASE_ADDR, BASE_ADDR + 10 + SAMPLE_DEPTH)` appears on the output port one cycle later with address, write data, read data, read/write select and valid all unchanged.
- R2: A request that hits the core is also forwarded one cycle later with address, write data, select (1 = write) and valid unchanged. For a local write, the read-data field passes through. For a local read, the read-data field carries the addressed value, zero-extended.
- R3: Configuration offsets 1 to 9 read back the full 16-bit value last written. Offset 1 is the signed trigger location, so a write of -69 reads back as 0xFFBB.
- R4: Offset 0 is the state register. After reset it reads 0 and the output valid is low. A write of 0 idles the core, a write of 1 arms it (and restarts recording), and writes of any other value are ignored. It reads 0 for idle, 1 for armed, 3 for capturing and 2 for done.
- R5: A core that is idle (0) or done (2) never starts a capture, whatever the probes do.
- R6: Probe k (a = 0, b = 1, c = 2, d = 3) has its operation at offset 2+2k and its argument at offset 3+2k. Only the argument's low bits, as many as the probe is wide, are compared. The operation codes are: 8 equal, 9 not equal, 10 unsigned greater than, 11 unsigned less than. Code 0 and every other code disable the probe.
- R7: The trigger is the OR of all enabled comparisons, evaluated on the probe values at each clock edge while armed. It is honoured only once P samples have been recorded since arming. P is the trigger location clamped to the range 0 to SAMPLE_DEPTH-1 (negative values give 0).
- R8: While armed or capturing, the core records the sample {d, c, b, a} (a in bit 0, d in bits 6:3) on each edge. Capture ends in state 2 once the memory holds P samples before the trigger sample, the trigger sample itself, and SAMPLE_DEPTH-P-1 samples after it.
- R9: After capture, sample i (0 = oldest) reads at offset 10+i, and the trigger sample is at i = P. Writes to the sample offsets are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| probe_a | input | 1 | Single-bit probe, sample bit 0 |
| probe_b | input | 1 | Single-bit probe, sample bit 1 |
| probe_c | input | 1 | Single-bit probe, sample bit 2 |
| probe_d | input | 4 | 4-bit probe, sample bits 6:3 |
| addr_i | input | 16 | Incoming request address |
| wdata_i | input | 16 | Incoming write data |
| rdata_i | input | 16 | Incoming read data from upstream |
| rw_i | input | 1 | Incoming select, 1 = write |
| valid_i | input | 1 | Incoming request strobe |
| addr_o | output | 16 | Forwarded address |
| wdata_o | output | 16 | Forwarded write data |
| rdata_o | output | 16 | Forwarded or supplied read data |
| rw_o | output | 1 | Forwarded select |
| valid_o | output | 1 | Forwarded strobe |

## Verification
On every cycle, the assertions check that the request fields are forwarded with one cycle of delay and that read data passes untouched for requests the core does not answer. They also check the state machine: an idle or done core stays put unless the bus writes the state, capture only moves forward to done, and a write of 1 always arms. Comparison operations, the OR of probes, the hold-off for the pre-trigger count, the clamping of the trigger location, and the placement of the trigger sample in the read-back window all depend on the stimulus history. Those are shown only by the bench scenarios, which compare every response with a behavioural model.

// File: rtl/la_pkg.sv
package la_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ARMED   = 2'd1,
    ST_DONE    = 2'd2,
    ST_CAPTURE = 2'd3
  } la_state_e;

  localparam int NUM_PROBES = 4;
  localparam int CFG_REGS   = 2 + 2 * NUM_PROBES;
  localparam int SAMPLE_W   = 7;

  localparam logic [15:0] OP_EQ = 16'd8;
  localparam logic [15:0] OP_NE = 16'd9;
  localparam logic [15:0] OP_GT = 16'd10;
  localparam logic [15:0] OP_LT = 16'd11;

  // width of probe k inside the packed sample word
  function automatic int probe_w(int k);
    return (k == NUM_PROBES - 1) ? 4 : 1;
  endfunction

  // lowest bit of probe k inside the packed sample word
  function automatic int probe_lsb(int k);
    return k;
  endfunction

endpackage

// File: rtl/la_probe_cmp.sv
module la_probe_cmp #(
  parameter int W = 1
) (
  input  logic [W-1:0] value,
  input  logic [15:0]  op,
  input  logic [W-1:0] arg,
  output logic         hit
);
  import la_pkg::*;

  always_comb begin
    case (op)
      OP_EQ:   hit = (value == arg);
      OP_NE:   hit = (value != arg);
      OP_GT:   hit = (value > arg);
      OP_LT:   hit = (value < arg);
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/la_sample_ram.sv
module la_sample_ram #(
  parameter int DEPTH = 128,
  parameter int WIDTH = 7,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/la_capture_ctrl.sv
module la_capture_ctrl #(
  parameter int DEPTH = 128,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm_req,
  input  logic              idle_req,
  input  logic              trig_hit,
  input  logic [PW-1:0]     pre_cnt,
  output la_pkg::la_state_e state,
  output logic              wr_en,
  output logic [PW-1:0]     wr_ptr,
  output logic [PW-1:0]     start_ptr
);
  import la_pkg::*;

  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [PW:0]   FULL = (PW+1)'(DEPTH);

  logic [PW:0]   filled_q;
  logic [PW-1:0] remain_q;
  logic [PW-1:0] ptr_next;
  logic [PW:0]   back_sum;
  logic [PW-1:0] back_ptr;
  logic          fire;

  assign wr_en    = (state == ST_ARMED) || (state == ST_CAPTURE);
  assign ptr_next = (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
  assign back_sum = {1'b0, wr_ptr} + FULL - {1'b0, pre_cnt};
  assign back_ptr = (back_sum >= FULL) ? PW'(back_sum - FULL) : back_sum[PW-1:0];
  assign fire     = trig_hit && (filled_q >= {1'b0, pre_cnt});

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      wr_ptr    <= '0;
      filled_q  <= '0;
      remain_q  <= '0;
      start_ptr <= '0;
    end else if (arm_req) begin
      state    <= ST_ARMED;
      wr_ptr   <= '0;
      filled_q <= '0;
    end else if (idle_req) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_ARMED: begin
          wr_ptr <= ptr_next;
          if (filled_q != FULL) filled_q <= filled_q + 1'b1;
          if (fire) begin
            start_ptr <= back_ptr;
            remain_q  <= LAST - pre_cnt;
            state     <= (pre_cnt == LAST) ? ST_DONE : ST_CAPTURE;
          end
        end
        ST_CAPTURE: begin
          wr_ptr   <= ptr_next;
          remain_q <= remain_q - 1'b1;
          if (remain_q == PW'(1)) state <= ST_DONE;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/bus_logic_analyzer.sv
module bus_logic_analyzer #(
  parameter int BASE_ADDR    = 0,
  parameter int SAMPLE_DEPTH = 128
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        probe_a,
  input  logic        probe_b,
  input  logic        probe_c,
  input  logic [3:0]  probe_d,
  input  logic [15:0] addr_i,
  input  logic [15:0] wdata_i,
  input  logic [15:0] rdata_i,
  input  logic        rw_i,
  input  logic        valid_i,
  output logic [15:0] addr_o,
  output logic [15:0] wdata_o,
  output logic [15:0] rdata_o,
  output logic        rw_o,
  output logic        valid_o
);
  import la_pkg::*;

  localparam int PW   = $clog2(SAMPLE_DEPTH);
  localparam int SPAN = CFG_REGS + SAMPLE_DEPTH;
  localparam logic [PW:0] FULL = (PW+1)'(SAMPLE_DEPTH);

  la_state_e         state_q;
  logic [15:0]       trig_q;
  logic [15:0]       op_q  [NUM_PROBES];
  logic [15:0]       arg_q [NUM_PROBES];
  logic [SAMPLE_W-1:0] probe_vec;
  logic [NUM_PROBES-1:0] hits;
  logic [31:0]       off;
  logic              local_hit, wr_hit, rd_hit;
  logic [15:0]       reg_rd;
  logic [PW-1:0]     pre_cnt;
  logic signed [31:0] tl_ext;
  logic              ram_we;
  logic [PW-1:0]     wr_ptr, start_ptr, rd_ptr;
  logic [PW:0]       s_idx, s_sum;
  logic [SAMPLE_W-1:0] ram_q;
  logic [15:0]       rdata_q;
  logic              sel_ram_q;

  assign probe_vec = {probe_d, probe_c, probe_b, probe_a};

  // address decode
  assign off       = 32'(addr_i) - 32'(BASE_ADDR);
  assign local_hit = (32'(addr_i) >= 32'(BASE_ADDR)) && (off < 32'(SPAN));
  assign wr_hit    = valid_i && local_hit && rw_i;
  assign rd_hit    = valid_i && local_hit && !rw_i;

  // pre-trigger count: trigger location clamped into the buffer
  assign tl_ext = 32'($signed(trig_q));
  always_comb begin
    if (tl_ext < 0)                      pre_cnt = '0;
    else if (tl_ext > SAMPLE_DEPTH - 1)  pre_cnt = PW'(SAMPLE_DEPTH - 1);
    else                                 pre_cnt = PW'(tl_ext);
  end

  // per-probe comparators
  for (genvar k = 0; k < NUM_PROBES; k++) begin : g_cmp
    localparam int WK = probe_w(k);
    localparam int LK = probe_lsb(k);
    la_probe_cmp #(.W(WK)) cmp_i (
      .value (probe_vec[LK +: WK]),
      .op    (op_q[k]),
      .arg   (arg_q[k][WK-1:0]),
      .hit   (hits[k])
    );
  end

  la_capture_ctrl #(.DEPTH(SAMPLE_DEPTH)) ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .arm_req   (wr_hit && (off == 32'd0) && (wdata_i == 16'd1)),
    .idle_req  (wr_hit && (off == 32'd0) && (wdata_i == 16'd0)),
    .trig_hit  (|hits),
    .pre_cnt   (pre_cnt),
    .state     (state_q),
    .wr_en     (ram_we),
    .wr_ptr    (wr_ptr),
    .start_ptr (start_ptr)
  );

  // read-back index: oldest sample sits at start_ptr
  assign s_idx  = (PW+1)'(off - 32'(CFG_REGS));
  assign s_sum  = {1'b0, start_ptr} + s_idx;
  assign rd_ptr = (s_sum >= FULL) ? PW'(s_sum - FULL) : s_sum[PW-1:0];

  la_sample_ram #(.DEPTH(SAMPLE_DEPTH), .WIDTH(SAMPLE_W)) ram_i (
    .clk   (clk),
    .we    (ram_we),
    .waddr (wr_ptr),
    .wdata (probe_vec),
    .raddr (rd_ptr),
    .rdata (ram_q)
  );

  // register read mux
  always_comb begin
    reg_rd = '0;
    if (off == 32'd0) reg_rd = {14'd0, state_q};
    if (off == 32'd1) reg_rd = trig_q;
    for (int k = 0; k < NUM_PROBES; k++) begin
      if (off == 32'(2 + 2 * k)) reg_rd = op_q[k];
      if (off == 32'(3 + 2 * k)) reg_rd = arg_q[k];
    end
  end

  // bus stage and configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_o    <= '0;
      wdata_o   <= '0;
      rw_o      <= 1'b0;
      valid_o   <= 1'b0;
      rdata_q   <= '0;
      sel_ram_q <= 1'b0;
      trig_q    <= '0;
      for (int k = 0; k < NUM_PROBES; k++) begin
        op_q[k]  <= '0;
        arg_q[k] <= '0;
      end
    end else begin
      addr_o    <= addr_i;
      wdata_o   <= wdata_i;
      rw_o      <= rw_i;
      valid_o   <= valid_i;
      rdata_q   <= rdata_i;
      sel_ram_q <= 1'b0;
      if (wr_hit) begin
        if (off == 32'd1) trig_q <= wdata_i;
        for (int k = 0; k < NUM_PROBES; k++) begin
          if (off == 32'(2 + 2 * k)) op_q[k]  <= wdata_i;
          if (off == 32'(3 + 2 * k)) arg_q[k] <= wdata_i;
        end
      end
      if (rd_hit) begin
        if (off < 32'(CFG_REGS)) rdata_q <= reg_rd;
        else                     sel_ram_q <= 1'b1;
      end
    end
  end

  assign rdata_o = sel_ram_q ? 16'(ram_q) : rdata_q;

endmodule

// File: rtl/la_checker.sv
module la_checker #(
  parameter int BASE_ADDR    = 0,
  parameter int SAMPLE_DEPTH = 128
) (
  input logic        clk,
  input logic        rst,
  input logic [15:0] addr_i,
  input logic [15:0] wdata_i,
  input logic [15:0] rdata_i,
  input logic        rw_i,
  input logic        valid_i,
  input logic [15:0] addr_o,
  input logic [15:0] wdata_o,
  input logic [15:0] rdata_o,
  input logic        rw_o,
  input logic        valid_o,
  input logic [1:0]  state
);
  localparam int SPAN = 10 + SAMPLE_DEPTH;

  logic mine, state_wr, answers;
  assign mine     = (32'(addr_i) >= 32'(BASE_ADDR)) &&
                    ((32'(addr_i) - 32'(BASE_ADDR)) < 32'(SPAN));
  assign state_wr = valid_i && rw_i && (32'(addr_i) == 32'(BASE_ADDR));
  assign answers  = valid_i && mine && !rw_i;

  // R2
  fwd_fields_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (addr_o == $past(addr_i)) && (wdata_o == $past(wdata_i)) &&
                    (rw_o == $past(rw_i)) && (valid_o == $past(valid_i)));

  // R1
  rdata_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(answers)) |-> (rdata_o == $past(rdata_i)));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == 2'd0 && !state_wr) |=> (state == 2'd0));

  // R5
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == 2'd2 && !state_wr) |=> (state == 2'd2));

  // R8
  capture_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    (state == 2'd3 && !state_wr) |=> (state == 2'd3 || state == 2'd2));

  // R4
  arm_write_chk: assert property (@(posedge clk) disable iff (rst)
    (state_wr && wdata_i == 16'd1) |=> (state == 2'd1));

endmodule

bind bus_logic_analyzer la_checker #(
  .BASE_ADDR(BASE_ADDR), .SAMPLE_DEPTH(SAMPLE_DEPTH)
) chk_i (
  .clk(clk), .rst(rst),
  .addr_i(addr_i), .wdata_i(wdata_i), .rdata_i(rdata_i), .rw_i(rw_i), .valid_i(valid_i),
  .addr_o(addr_o), .wdata_o(wdata_o), .rdata_o(rdata_o), .rw_o(rw_o), .valid_o(valid_o),
  .state(state_q)
);

// File: tb/bus_logic_analyzer_tb_top.sv
module bus_logic_analyzer_tb_top;
  localparam int BASE  = 0;
  localparam int DEPTH = 128;
  localparam int CFG   = 10;
  localparam int SPAN  = CFG + DEPTH;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [15:0] b_addr = '0, b_wd = '0, b_rdin = '0;
  logic        b_rw = 1'b0, b_valid = 1'b0;
  logic        pa = 1'b0, pb = 1'b0, pc = 1'b0;
  logic [3:0]  pd = '0;
  logic        cnt_en = 1'b0;

  wire [15:0] o_addr, o_wd, o_rd;
  wire        o_rw, o_valid;

  bus_logic_analyzer #(.BASE_ADDR(BASE), .SAMPLE_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst),
    .probe_a(pa), .probe_b(pb), .probe_c(pc), .probe_d(pd),
    .addr_i(b_addr), .wdata_i(b_wd), .rdata_i(b_rdin), .rw_i(b_rw), .valid_i(b_valid),
    .addr_o(o_addr), .wdata_o(o_wd), .rdata_o(o_rd), .rw_o(o_rw), .valid_o(o_valid)
  );

  always @(negedge clk) if (cnt_en) pd = pd + 4'd1;

  int total = 0, bad = 0, cyc = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int          m_state = 0;
  logic [15:0] m_trig = '0;
  logic [15:0] m_op [4];
  logic [15:0] m_arg [4];
  int          hist [$];
  int          cap [DEPTH];
  int          m_tidx = 0, m_pre = 0, m_rem = 0;
  logic [15:0] e_addr = '0, e_wd = '0, e_rd = '0;
  logic        e_rw = 1'b0, e_v = 1'b0;
  bit          e_care = 1'b1, m_live = 1'b0;
  string       e_tag = "R1";

  function automatic int pre_of(logic [15:0] t);
    int s = int'($signed(t));
    if (s < 0) return 0;
    if (s > DEPTH - 1) return DEPTH - 1;
    return s;
  endfunction

  function automatic bit m_hit();
    bit h = 0;
    for (int k = 0; k < 4; k++) begin
      int v, a;
      v = (k == 0) ? int'(pa) : (k == 1) ? int'(pb) : (k == 2) ? int'(pc) : int'(pd);
      a = int'(m_arg[k]) & ((k == 3) ? 15 : 1);
      case (int'(m_op[k]))
        8:  h |= (v == a);
        9:  h |= (v != a);
        10: h |= (v > a);
        11: h |= (v < a);
        default: ;
      endcase
    end
    return h;
  endfunction

  task automatic m_finish();
    for (int i = 0; i < DEPTH; i++) cap[i] = hist[m_tidx - m_pre + i];
    m_state = 2;
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_state = 0; m_trig = '0;
      for (int k = 0; k < 4; k++) begin m_op[k] = '0; m_arg[k] = '0; end
      hist.delete();
      e_addr = '0; e_wd = '0; e_rd = '0; e_rw = 0; e_v = 0; e_care = 1;
    end else begin
      int off, smp, filled, p;
      bit loc;
      m_live = 1;
      off = int'(b_addr) - BASE;
      loc = b_valid && off >= 0 && off < SPAN;
      e_addr = b_addr; e_wd = b_wd; e_rw = b_rw; e_v = b_valid; e_rd = b_rdin;
      e_care = 1; e_tag = loc ? "R2" : "R1";
      if (loc && !b_rw) begin
        if (off == 0) e_rd = 16'(m_state);
        else if (off == 1) e_rd = m_trig;
        else if (off < CFG) e_rd = (off % 2 == 0) ? m_op[(off - 2) / 2] : m_arg[(off - 3) / 2];
        else begin
          e_tag = "R9";
          if (m_state == 2) e_rd = 16'(cap[off - CFG]);
          else e_care = 0;
        end
      end
      smp = int'(pa) | (int'(pb) << 1) | (int'(pc) << 2) | (int'(pd) << 3);
      if (m_state == 1) begin
        filled = hist.size();
        hist.push_back(smp);
        p = pre_of(m_trig);
        if (filled >= p && m_hit()) begin
          m_tidx = hist.size() - 1; m_pre = p; m_rem = DEPTH - p - 1;
          if (m_rem == 0) m_finish(); else m_state = 3;
        end
      end else if (m_state == 3) begin
        hist.push_back(smp);
        m_rem--;
        if (m_rem == 0) m_finish();
      end
      if (loc && b_rw) begin
        if (off == 0) begin
          if (b_wd == 16'd0) m_state = 0;
          if (b_wd == 16'd1) begin m_state = 1; hist.delete(); end
        end else if (off == 1) m_trig = b_wd;
        else if (off < CFG) begin
          if (off % 2 == 0) m_op[(off - 2) / 2] = b_wd; else m_arg[(off - 3) / 2] = b_wd;
        end
      end
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (m_live && !rst) begin
      chk(o_addr == e_addr && o_wd == e_wd && o_rw == e_rw && o_valid == e_v,
          "R2", "forwarded fields", {o_addr, o_wd, o_rw, o_valid}, {e_addr, e_wd, e_rw, e_v});
      if (e_care) chk(o_rd == e_rd, e_tag, "read data", o_rd, e_rd);
    end
  end

  // ---------------- stimulus ----------------
  task automatic bus(input logic [15:0] a, input bit w, input logic [15:0] wd,
                     input logic [15:0] rdin, output logic [15:0] rd);
    @(negedge clk);
    b_addr = a; b_rw = w; b_wd = wd; b_rdin = rdin; b_valid = 1'b1;
    @(negedge clk);
    b_valid = 1'b0; b_rdin = '0;
    rd = o_rd;
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    logic [15:0] dummy;
    bus(16'(BASE + a), 1'b1, d, 16'h0, dummy);
  endtask

  task automatic rd(input int a, output logic [15:0] v);
    bus(16'(BASE + a), 1'b0, 16'h0, 16'h0, v);
  endtask

  task automatic wait_done(input string req);
    logic [15:0] v = '0;
    for (int i = 0; i < 400; i++) begin
      rd(0, v);
      if (v == 16'd2) break;
    end
    chk(v == 16'd2, req, "capture completes", v, 2);
  endtask

  task automatic set_ops(input logic [15:0] a, b, c, d);
    wr(2, a); wr(4, b); wr(6, c); wr(8, d);
  endtask

  logic [15:0] v, s0;
  int hits_a;

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(o_valid == 1'b0, "R4", "valid after reset", o_valid, 0);
    rd(0, v); chk(v == 16'd0, "R4", "state after reset", v, 0);

    // R1: pass-through of foreign requests, including the first address past the window
    bus(16'h4000, 1'b0, 16'h0, 16'h1234, v);
    chk(v == 16'h1234 && o_addr == 16'h4000, "R1", "foreign read passes", v, 16'h1234);
    bus(16'(BASE + SPAN), 1'b0, 16'h0, 16'hBEEF, v);
    chk(v == 16'hBEEF, "R1", "address just past window", v, 16'hBEEF);
    bus(16'h4001, 1'b1, 16'h5A5A, 16'h0, v);
    chk(o_wd == 16'h5A5A && o_rw == 1'b1, "R1", "foreign write passes", o_wd, 16'h5A5A);
    // R2: local write lets upstream read data through
    bus(16'(BASE + 1), 1'b1, 16'h0003, 16'h7777, v);
    chk(v == 16'h7777, "R2", "local write keeps rdata", v, 16'h7777);

    // R4: state register writes
    wr(0, 16'd5); rd(0, v); chk(v == 16'd0, "R4", "value 5 ignored", v, 0);
    wr(0, 16'd1); rd(0, v); chk(v == 16'd1, "R4", "armed", v, 1);
    wr(0, 16'd0); rd(0, v); chk(v == 16'd0, "R4", "idled", v, 0);

    // R3: configuration read-back
    wr(1, -16'sd69); rd(1, v); chk(v == 16'hFFBB, "R3", "signed trigger location", v, 16'hFFBB);
    for (int k = 2; k < CFG; k++) wr(k, 16'hA500 + 16'(k));
    for (int k = 2; k < CFG; k++) begin
      rd(k, v); chk(v == 16'hA500 + 16'(k), "R3", "config read-back", v, 16'hA500 + 16'(k));
    end
    set_ops(0, 0, 0, 0);

    // R5: idle core ignores a matching probe
    wr(2, 16'd8); wr(3, 16'd1); pa = 1'b1;
    repeat (6) @(negedge clk);
    rd(0, v); chk(v == 16'd0, "R5", "idle does not trigger", v, 0);
    pa = 1'b0;

    // R8/R9: equality on probe a, P = 4
    wr(1, 16'd4); cnt_en = 1'b1;
    wr(0, 16'd1);
    repeat (10) @(negedge clk);
    pa = 1'b1; @(negedge clk); pa = 1'b0;
    wait_done("R8");
    hits_a = 0;
    for (int i = 0; i < DEPTH; i++) begin
      rd(CFG + i, v);
      if (i == 0) s0 = v;
      if (v[0]) hits_a++;
      if (i == 4) chk(v[0] == 1'b1, "R9", "trigger sample at P", v, 1);
    end
    chk(hits_a == 1, "R8", "single trigger sample kept", hits_a, 1);
    // R5/R9: done core ignores probes and sample writes
    pa = 1'b1; repeat (4) @(negedge clk); pa = 1'b0;
    wr(CFG, 16'h007F);
    rd(CFG, v); chk(v == s0, "R9", "sample write ignored", v, s0);
    rd(0, v); chk(v == 16'd2, "R5", "done holds", v, 2);
    wr(0, 16'd7); rd(0, v); chk(v == 16'd2, "R4", "value 7 ignored while done", v, 2);

    // R6/R7: greater-than on probe d, negative location clamps to P = 0
    set_ops(0, 0, 0, OP_GT_V()); wr(9, 16'd12); wr(1, -16'sd69);
    wr(0, 16'd1);
    wait_done("R7");
    rd(CFG, v); chk(v[6:3] > 4'd12, "R7", "trigger sample first", v[6:3], 13);
    rd(CFG + 1, s0); chk(s0[6:3] == v[6:3] + 4'd1, "R8", "samples consecutive", s0[6:3], v[6:3] + 4'd1);

    // R7: hold-off with location above depth (P = DEPTH-1)
    cnt_en = 1'b0;
    set_ops(0, 16'd8, 0, 0); wr(5, 16'd1); pb = 1'b1; wr(1, 16'd200);
    wr(0, 16'd1);
    repeat (20) @(negedge clk);
    rd(0, v); chk(v == 16'd1, "R7", "hold-off before P samples", v, 1);
    wait_done("R7");
    rd(CFG + DEPTH - 1, v); chk(v[1] == 1'b1, "R9", "trigger sample last", v, 1);
    pb = 1'b0;

    // R6/R7: OR of probes, not-equal on probe c
    set_ops(16'd8, 0, 16'd9, 0); wr(3, 16'd1); wr(7, 16'd0); wr(1, 16'd0);
    wr(0, 16'd1);
    repeat (20) @(negedge clk);
    rd(0, v); chk(v == 16'd1, "R7", "no enabled match, stays armed", v, 1);
    pc = 1'b1;
    wait_done("R6");
    rd(CFG, v); chk(v[2] == 1'b1, "R6", "not-equal fired on probe c", v, 1);
    pc = 1'b0;

    // R6: less-than on probe d, P = 2
    set_ops(0, 0, 0, 16'd11); wr(9, 16'd3); wr(1, 16'd2); cnt_en = 1'b1;
    wr(0, 16'd1);
    wait_done("R6");
    rd(CFG + 2, v); chk(v[6:3] < 4'd3, "R6", "less-than trigger sample", v[6:3], 0);
    cnt_en = 1'b0;

    repeat (4) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic logic [15:0] OP_GT_V();
    return 16'd10;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule